// File: doc/BRIEF.md
# Signaling Change-of-State Event Queue

This block watches a stream of per-time-slot signaling samples. Each sample carries a link number, a time-slot number, a four-bit code and a signaling mode. The block masks the code down to the bits that the mode uses and compares the result with the value it last saw for that slot. When the two differ, it appends a packed event word to an event queue. A host drains the queue through one 16-bit read word, and each read strobe removes the entry at the head. Every word describes itself: it carries a flag that says the entry is real and a flag that says more entries wait behind it. The host therefore needs no separate status register.

An interrupt output tells the host when to drain the queue. It fires when the queue holds more entries than a depth threshold, or when a hold timer that counts 125 µs ticks has run past a timer threshold while entries are waiting. If an event arrives while the queue is full, the block throws the stored backlog away, keeps the new event, and latches an overflow cause. That cause holds the interrupt until the host clears it. A global enable gates all event generation.

Top module: `sig_cos_queue`

## Requirements
- R1: The read word places the signaling code in bits 3:0 (D,C,B,A with A in bit 0), the time-slot number in bits 8:4, the link number in bits 13:9, the valid flag V in bit 14 and the more flag M in bit 15. Each read strobe pops the head, and entries come out in the order they arrived.
- R2: When the queue is empty, the read word is all zeros. A read strobe on an empty queue changes nothing.
- R3: M is 1 only when at least one further entry is stored behind the one shown, and M=1 implies V=1.
- R4: A sample raises an event only when its masked code differs from the masked code last stored for that slot. Every slot's stored value is 0 after reset, and repeating a value raises no event.
- R5: The mode masks the code. Mode 2'b00 and 2'b11 keep all four bits, 2'b01 keeps B and A, and 2'b10 keeps A only. Masked bits read as 0 in the event word and take no part in the comparison.
- R6: A sample whose link is 28 or higher, or whose slot is 24 or higher, is ignored.
- R7: While the enable is low, no entry is pushed and the interrupt stays low. Samples still update the stored per-slot values.
- R8: The depth cause is active while the stored entry count is greater than the 10-bit depth threshold.
- R9: The timer counts ticks from the moment the queue becomes non-empty. Its cause is active while entries are present and the count has reached the 16-bit timer threshold. The count returns to 0 when the queue empties.
- R10: With both thresholds at 0, any stored entry raises the interrupt.
- R11: A push into a full queue discards the stored entries and keeps the new one as the only entry. It also latches an overflow cause that holds the interrupt high until the clear strobe.
- R12: The queue holds up to 672 entries without loss.
- R13: After reset the queue is empty, the read word is 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cos_en | input | 1 | Global event enable |
| smp_valid | input | 1 | Sample strobe |
| smp_link | input | 5 | Link number of the sample |
| smp_slot | input | 5 | Time-slot number of the sample |
| smp_code | input | 4 | Raw signaling code D,C,B,A |
| smp_mode | input | 2 | Signaling mode of the slot |
| depth_thr | input | 10 | Depth threshold |
| timer_thr | input | 16 | Hold timer threshold in ticks |
| tick | input | 1 | One-cycle 125 µs timebase pulse |
| rd_stb | input | 1 | Read strobe; pops the head entry |
| ovf_clr | input | 1 | Clears the latched overflow cause |
| rd_data | output | 16 | Self-describing event word |
| irq | output | 1 | Host interrupt |

## Verification
Some properties can be checked on every cycle, and assertions cover them. The entry count never goes past capacity. An overflow always leaves exactly one entry. The more flag never appears without the valid flag, and an empty word is all zeros. The overflow cause stays set until it is cleared. The queue count holds still while the enable is low and nothing is read. A slot in four-state mode never pushes its upper code bits. The timer idles at zero while the queue is empty. Other behaviours need the bench's scenarios. These include which samples count as changes, given the per-slot history and the masking. They also include the order in which entries come out, the tick count at which the timer fires, and the discard-and-continue sequence around an overflow.

// File: rtl/sig_cos_pkg.sv
package sig_cos_pkg;

  localparam int LINK_W = 5;
  localparam int SLOT_W = 5;
  localparam int CODE_W = 4;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_QUAD  = 2'b01,
    MODE_BIN   = 2'b10,
    MODE_FULL2 = 2'b11
  } sig_mode_e;

  typedef struct packed {
    logic [LINK_W-1:0] link;
    logic [SLOT_W-1:0] slot;
    logic [CODE_W-1:0] code;
  } cos_entry_t;

  // Keep only the code bits that the mode uses
  function automatic logic [CODE_W-1:0] mask_code(logic [CODE_W-1:0] code,
                                                  logic [1:0] mode);
    case (mode)
      MODE_QUAD: mask_code = code & 4'b0011;
      MODE_BIN:  mask_code = code & 4'b0001;
      default:   mask_code = code;
    endcase
  endfunction

  // Self-describing host word; zero when nothing is valid
  function automatic logic [WORD_W-1:0] pack_word(logic more, logic valid,
                                                  cos_entry_t e);
    pack_word = valid ? {more, 1'b1, e} : '0;
  endfunction

endpackage

// File: rtl/cos_detect.sv
module cos_detect
  import sig_cos_pkg::*;
#(
  parameter int NUM_LINKS = 28,
  parameter int SLOTS     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              smp_valid,
  input  logic [LINK_W-1:0] smp_link,
  input  logic [SLOT_W-1:0] smp_slot,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [1:0]        smp_mode,
  output logic              push,
  output cos_entry_t        push_entry
);

  localparam int CELLS = NUM_LINKS * SLOTS;
  localparam int IDX_W = $clog2(CELLS);

  logic [CODE_W-1:0] last_q [CELLS];
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic              sample_ok;
  logic [CODE_W-1:0] masked;
  logic [CODE_W-1:0] prev;
  logic              changed;

  always_comb begin
    in_range  = (int'(smp_link) < NUM_LINKS) && (int'(smp_slot) < SLOTS);
    idx       = IDX_W'(smp_link) * IDX_W'(SLOTS) + IDX_W'(smp_slot);
    sample_ok = smp_valid && in_range;
    masked    = mask_code(smp_code, smp_mode);
    prev      = in_range ? last_q[idx] : '0;
    changed   = sample_ok && (masked != prev);
    push      = changed && en;
    push_entry.link = smp_link;
    push_entry.slot = smp_slot;
    push_entry.code = masked;
  end

  // History is tracked whether or not events are enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) last_q[i] <= '0;
    end else if (sample_ok) begin
      last_q[idx] <= masked;
    end
  end

  // R5: a four-state slot never emits its upper code bits
  p_quad_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && smp_mode == MODE_QUAD) |-> (push_entry.code[3:2] == 2'b00));

  // R6: out-of-range samples never push
  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && int'(smp_slot) >= SLOTS) |-> !push);

endmodule

// File: rtl/cos_fifo.sv
module cos_fifo
  import sig_cos_pkg::*;
#(
  parameter int DEPTH = 672
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  cos_entry_t                 push_entry,
  input  logic                       pop,
  output cos_entry_t                 head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovf
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  cos_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, empty, do_pop;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    step = (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full   = (int'(count) == DEPTH);
    empty  = (count == '0);
    do_pop = pop && !empty;
    ovf    = push && full && !do_pop;
    head   = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (ovf) begin
      // Drop the backlog; the new entry becomes the sole entry
      rd_ptr <= wr_ptr;
      wr_ptr <= step(wr_ptr);
      count  <= CNT_W'(1);
    end else begin
      if (push)   wr_ptr <= step(wr_ptr);
      if (do_pop) rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(do_pop);
    end
  end

  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  p_ovf_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == CNT_W'(1)));

  p_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/cos_irq.sv
module cos_irq #(
  parameter int CNT_W = 10,
  parameter int DTH_W = 10,
  parameter int TTH_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  input  logic [DTH_W-1:0] depth_thr,
  input  logic [TTH_W-1:0] timer_thr,
  input  logic             tick,
  input  logic             ovf,
  input  logic             ovf_clr,
  output logic             irq
);

  logic [TTH_W-1:0] timer_cnt;
  logic             ovf_flag;
  logic             depth_hit, timer_hit, pending;

  always_comb begin
    pending   = (count != '0);
    depth_hit = 32'(count) > 32'(depth_thr);
    timer_hit = pending && (timer_cnt >= timer_thr);
    irq       = en && (depth_hit || timer_hit || ovf_flag);
  end

  // The timer idles at zero while empty, so it restarts on the empty-to-busy step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     timer_cnt <= '0;
    else if (!pending)              timer_cnt <= '0;
    else if (tick && ~&timer_cnt)   timer_cnt <= timer_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf)     ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_timer_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> (timer_cnt == '0));

endmodule

// File: rtl/sig_cos_queue.sv
module sig_cos_queue
  import sig_cos_pkg::*;
#(
  parameter int NUM_LINKS = 28,
  parameter int SLOTS     = 24,
  parameter int DEPTH     = 672
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cos_en,
  input  logic        smp_valid,
  input  logic [4:0]  smp_link,
  input  logic [4:0]  smp_slot,
  input  logic [3:0]  smp_code,
  input  logic [1:0]  smp_mode,
  input  logic [9:0]  depth_thr,
  input  logic [15:0] timer_thr,
  input  logic        tick,
  input  logic        rd_stb,
  input  logic        ovf_clr,
  output logic [15:0] rd_data,
  output logic        irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             ev_push;
  cos_entry_t       ev_entry;
  cos_entry_t       head;
  logic [CNT_W-1:0] count;
  logic             ev_ovf;

  cos_detect #(.NUM_LINKS(NUM_LINKS), .SLOTS(SLOTS)) u_detect (
    .clk(clk), .rst_n(rst_n), .en(cos_en),
    .smp_valid(smp_valid), .smp_link(smp_link), .smp_slot(smp_slot),
    .smp_code(smp_code), .smp_mode(smp_mode),
    .push(ev_push), .push_entry(ev_entry)
  );

  cos_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .push_entry(ev_entry),
    .pop(rd_stb), .head(head), .count(count), .ovf(ev_ovf)
  );

  cos_irq #(.CNT_W(CNT_W), .DTH_W(10), .TTH_W(16)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(cos_en), .count(count),
    .depth_thr(depth_thr), .timer_thr(timer_thr), .tick(tick),
    .ovf(ev_ovf), .ovf_clr(ovf_clr), .irq(irq)
  );

  assign rd_data = pack_word(count > CNT_W'(1), count != '0, head);

  p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[14] |-> (rd_data == 16'h0));

  p_more_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] |-> rd_data[14]);

  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cos_en && !rd_stb) |=> $stable(count));

endmodule

// File: tb/sig_cos_queue_tb.sv
module sig_cos_queue_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cos_en = 1'b1;
  logic        smp_valid = 1'b0;
  logic [4:0]  smp_link = '0;
  logic [4:0]  smp_slot = '0;
  logic [3:0]  smp_code = '0;
  logic [1:0]  smp_mode = '0;
  logic [9:0]  depth_thr = 10'd1023;
  logic [15:0] timer_thr = 16'hFFFF;
  logic        tick = 1'b0;
  logic        rd_stb = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [15:0] rd_data;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sig_cos_queue u_dut (
    .clk(clk), .rst_n(rst_n), .cos_en(cos_en), .smp_valid(smp_valid),
    .smp_link(smp_link), .smp_slot(smp_slot), .smp_code(smp_code),
    .smp_mode(smp_mode), .depth_thr(depth_thr), .timer_thr(timer_thr),
    .tick(tick), .rd_stb(rd_stb), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .irq(irq)
  );

  // {link, slot, code, mode, expect_event, expect_code}
  localparam logic [20:0] VECS [14] = '{
    {5'd0,  5'd0,  4'h5, 2'd0, 1'b1, 4'h5},
    {5'd0,  5'd0,  4'h5, 2'd0, 1'b0, 4'h0},
    {5'd0,  5'd0,  4'h7, 2'd1, 1'b1, 4'h3},
    {5'd0,  5'd0,  4'hF, 2'd1, 1'b0, 4'h0},
    {5'd0,  5'd0,  4'hE, 2'd2, 1'b1, 4'h0},
    {5'd27, 5'd23, 4'h9, 2'd0, 1'b1, 4'h9},
    {5'd28, 5'd0,  4'h9, 2'd0, 1'b0, 4'h0},
    {5'd3,  5'd24, 4'h9, 2'd0, 1'b0, 4'h0},
    {5'd5,  5'd10, 4'h1, 2'd2, 1'b1, 4'h1},
    {5'd5,  5'd10, 4'hD, 2'd3, 1'b1, 4'hD},
    {5'd5,  5'd10, 4'hD, 2'd0, 1'b0, 4'h0},
    {5'd12, 5'd7,  4'h0, 2'd0, 1'b0, 4'h0},
    {5'd12, 5'd7,  4'h8, 2'd2, 1'b0, 4'h0},
    {5'd12, 5'd7,  4'h8, 2'd0, 1'b1, 4'h8}
  };

  function automatic logic [15:0] word(logic m, logic v, logic [4:0] l,
                                       logic [4:0] s, logic [3:0] c);
    if (!v) return 16'h0;
    return {m, v, l, s, c};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample(logic [4:0] l, logic [4:0] s, logic [3:0] c, logic [1:0] m);
    @(negedge clk);
    smp_link = l; smp_slot = s; smp_code = c; smp_mode = m; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R13
    chk("R13 reset word", 32'(rd_data), 32'h0);
    chk("R13 reset irq", 32'(irq), 32'h0);

    // R1 R4 R5 R6 vector walk, popping every event at once
    for (int i = 0; i < 14; i++) begin
      logic [20:0] v;
      v = VECS[i];
      sample(v[20:16], v[15:11], v[10:7], v[6:5]);
      if (v[4]) begin
        chk("R1 R4 R5 event word", 32'(rd_data),
            32'(word(1'b0, 1'b1, v[20:16], v[15:11], v[3:0])));
        pop();
      end else begin
        chk("R4 R6 no event", 32'(rd_data), 32'h0);
      end
    end

    // R1 R3 order and more flag; R2 empty read
    sample(5'd1, 5'd1, 4'h1, 2'd0);
    sample(5'd2, 5'd2, 4'h2, 2'd0);
    sample(5'd3, 5'd3, 4'h3, 2'd0);
    chk("R3 first more", 32'(rd_data), 32'(word(1'b1, 1'b1, 5'd1, 5'd1, 4'h1)));
    pop();
    chk("R1 R3 second", 32'(rd_data), 32'(word(1'b1, 1'b1, 5'd2, 5'd2, 4'h2)));
    pop();
    chk("R3 last no more", 32'(rd_data), 32'(word(1'b0, 1'b1, 5'd3, 5'd3, 4'h3)));
    pop();
    chk("R2 empty word", 32'(rd_data), 32'h0);
    pop();
    chk("R2 read on empty", 32'(rd_data), 32'h0);
    sample(5'd4, 5'd4, 4'h4, 2'd0);
    chk("R2 queue intact after empty read", 32'(rd_data),
        32'(word(1'b0, 1'b1, 5'd4, 5'd4, 4'h4)));
    pop();

    // R8 depth cause
    depth_thr = 10'd2;
    sample(5'd6, 5'd0, 4'h1, 2'd0);
    sample(5'd6, 5'd1, 4'h1, 2'd0);
    chk("R8 at threshold", 32'(irq), 32'h0);
    sample(5'd6, 5'd2, 4'h1, 2'd0);
    chk("R8 above threshold", 32'(irq), 32'h1);
    pop();
    chk("R8 back at threshold", 32'(irq), 32'h0);
    pop();
    pop();

    // R9 timer cause
    depth_thr = 10'd10;
    timer_thr = 16'd3;
    sample(5'd7, 5'd0, 4'h2, 2'd0);
    chk("R9 no ticks", 32'(irq), 32'h0);
    pulse_tick();
    pulse_tick();
    chk("R9 two ticks", 32'(irq), 32'h0);
    pulse_tick();
    chk("R9 three ticks", 32'(irq), 32'h1);
    pop();
    chk("R9 cleared on empty", 32'(irq), 32'h0);
    sample(5'd7, 5'd1, 4'h2, 2'd0);
    chk("R9 restart from zero", 32'(irq), 32'h0);
    pop();

    // R10 default thresholds
    depth_thr = 10'd0;
    timer_thr = 16'd0;
    chk("R10 idle", 32'(irq), 32'h0);
    sample(5'd8, 5'd0, 4'h3, 2'd0);
    chk("R10 any entry", 32'(irq), 32'h1);
    pop();
    chk("R10 empty again", 32'(irq), 32'h0);

    // R7 enable gating
    cos_en = 1'b0;
    sample(5'd1, 5'd9, 4'h6, 2'd0);
    chk("R7 no entry while disabled", 32'(rd_data), 32'h0);
    chk("R7 no irq while disabled", 32'(irq), 32'h0);
    cos_en = 1'b1;
    sample(5'd1, 5'd9, 4'h6, 2'd0);
    chk("R7 history updated while disabled", 32'(rd_data), 32'h0);

    // R12 capacity and R11 overflow
    depth_thr = 10'd1023;
    timer_thr = 16'hFFFF;
    do_reset();
    for (int l = 0; l < 28; l++) begin
      for (int s = 0; s < 24; s++) begin
        @(negedge clk);
        smp_link = 5'(l); smp_slot = 5'(s); smp_code = 4'h1; smp_mode = 2'd0;
        smp_valid = 1'b1;
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R12 full head", 32'(rd_data), 32'(word(1'b1, 1'b1, 5'd0, 5'd0, 4'h1)));
    chk("R12 full no irq", 32'(irq), 32'h0);
    sample(5'd0, 5'd0, 4'h2, 2'd0);
    chk("R11 only new entry", 32'(rd_data), 32'(word(1'b0, 1'b1, 5'd0, 5'd0, 4'h2)));
    chk("R11 irq on overflow", 32'(irq), 32'h1);
    pop();
    chk("R11 empty after pop", 32'(rd_data), 32'h0);
    chk("R11 irq held", 32'(irq), 32'h1);
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R11 irq cleared", 32'(irq), 32'h0);
    sample(5'd9, 5'd9, 4'h5, 2'd0);
    chk("R11 stores normally after", 32'(rd_data),
        32'(word(1'b0, 1'b1, 5'd9, 5'd9, 4'h5)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule